// File: doc/BRIEF.md
# Two-Channel Serial Port Error and Status Flags

This block holds the status flags of a two-channel synchronous serial port. For each channel it keeps three flags. The transmit-empty flag asks the core for data. The receive-overrun flag marks a word that arrived while there was no room for it. The transmit-underrun flag marks a transmit slot that came up with nothing new to send. Each channel works either with a FIFO or with a single holding register, and the FIFO-enable control for that channel chooses which one the flags observe. The shifters, the clocking, the frame sync and the storage sit outside the block. They appear here only as level, full and empty inputs and as a time-slot strobe.

The overrun and underrun flags are sticky. A status read made while a flag is set clears it, and so does a soft reset or a power-on reset. An underrun also sends a one-cycle repeat pulse to the transmitter, which then sends the previous word again. The flags, combined with per-flag enables and a global receive or transmit enable, drive one registered interrupt line. Channel 1 works only in two-channel mode. In network mode, a slot whose transmit mask bit is set cannot cause an underrun.

Top module: `sport_err_status`

## Requirements
- R1: While the power-on reset (rst_n low) is applied, every output is 0.
- R2: With the channel's FIFO enabled, tx_empty for that channel is 1 in the cycle after its FIFO level is at or below tx_wmark, and 0 in the cycle after the level is above it.
- R3: With the channel's FIFO disabled, tx_empty for that channel is 1 in the cycle after tx_hold_full is 0, and 0 in the cycle after it is 1.
- R4: When two_ch is 0, every channel 1 output (bit 1 of tx_empty, rx_ovr, tx_unr and tx_repeat) is 0 in the following cycle, whatever the channel 1 inputs are.
- R5: rx_ovr of a channel becomes 1 in the cycle after rx_sr_full is 1 and the destination is full. The destination is rx_fifo_full when the FIFO is enabled and rx_hold_full when it is disabled. A full flag for the destination that is not selected does not set it.
- R6: tx_unr of a channel becomes 1 in the cycle after tx_en, tx_sr_empty, that channel's tx_empty output and slot_strobe are all 1. tx_repeat pulses for exactly that one cycle.
- R7: When net_mode is 1, a slot_strobe whose slot_mask bit at index slot_idx is 1 causes no underrun. When net_mode is 0, the mask is ignored.
- R8: rx_ovr and tx_unr hold at 1 until a cycle with stat_rd at 1, and are 0 in the cycle after that read.
- R9: If a set condition and stat_rd occur in the same cycle, the flag is still 1 in the following cycle.
- R10: irq in each cycle equals, from the previous cycle, the OR of (ie_rx_glob AND any rx_ovr bit with its ie_roe bit set) and (ie_tx_glob AND any tx_unr bit with its ie_tue bit set).
- R11: In the cycle after soft_rst is 1, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst | input | 1 | Block soft reset, synchronous |
| two_ch | input | 1 | Two-channel mode; enables channel 1 |
| net_mode | input | 1 | Network mode; slot mask applies |
| fifo_en | input | 2 | Per-channel FIFO enable (bit n = channel n) |
| tx_level | input | 2*LVL_W | Tx FIFO levels; channel n at bits [n*LVL_W +: LVL_W] |
| tx_wmark | input | LVL_W | Tx FIFO empty watermark |
| tx_hold_full | input | 2 | Tx holding register full |
| rx_fifo_full | input | 2 | Rx FIFO full |
| rx_hold_full | input | 2 | Rx holding register full |
| rx_sr_full | input | 2 | Receive shift register full |
| tx_sr_empty | input | 2 | Transmit shift register empty |
| tx_en | input | 2 | Transmitter enable |
| slot_strobe | input | 1 | Transmit time slot occurs |
| slot_idx | input | SLOT_W | Index of the current slot |
| slot_mask | input | NSLOT | Transmit slot mask, 1 = slot masked |
| stat_rd | input | 1 | Status register read strobe |
| ie_rx_glob | input | 1 | Global receive interrupt enable |
| ie_tx_glob | input | 1 | Global transmit interrupt enable |
| ie_roe | input | 2 | Per-channel overrun interrupt enable |
| ie_tue | input | 2 | Per-channel underrun interrupt enable |
| tx_empty | output | 2 | Transmit-empty flag, 1 = core must write |
| rx_ovr | output | 2 | Sticky receive-overrun flag |
| tx_unr | output | 2 | Sticky transmit-underrun flag |
| tx_repeat | output | 2 | One-cycle pulse: resend the previous word |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench first drives the holding-register full flag while the FIFO is enabled. A design that picks the wrong overrun destination would flag an overrun that never happened. It then issues a status read in the same cycle as a fresh overrun. A design in which the clear wins would lose that event. A masked slot in network mode, and the same mask in normal mode, show whether the mask is applied only where it belongs. The remaining checks cover channel 1 outputs with two-channel mode off, which a careless design would let leak, and the one-cycle lag of the interrupt behind the flags and enables.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int NCH = 2;

    typedef struct packed {
        logic tx_empty;
        logic rx_ovr;
        logic tx_unr;
        logic tx_repeat;
    } chan_flags_t;
endpackage

// File: rtl/sport_txe.sv
module sport_txe #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             active,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] wmark,
    input  logic             hold_full,
    output logic             tx_empty
);
    logic empty_d, empty_q;

    always_comb begin
        empty_d = 1'b0;
        if (active && !soft_rst) begin
            if (fifo_en) empty_d = (level <= wmark);
            else         empty_d = !hold_full;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) empty_q <= 1'b0;
        else        empty_q <= empty_d;
    end

    assign tx_empty = empty_q;
endmodule

// File: rtl/sport_chan.sv
module sport_chan
    import sport_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             active,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_wmark,
    input  logic             tx_hold_full,
    input  logic             rx_fifo_full,
    input  logic             rx_hold_full,
    input  logic             rx_sr_full,
    input  logic             tx_sr_empty,
    input  logic             tx_en,
    input  logic             slot_hit,
    input  logic             stat_rd,
    output chan_flags_t      flags
);
    chan_flags_t st_d, st_q;
    logic        txe;
    logic        ovr_set, unr_set;

    sport_txe #(.LVL_W(LVL_W)) u_txe (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .active   (active),
        .fifo_en  (fifo_en),
        .level    (tx_level),
        .wmark    (tx_wmark),
        .hold_full(tx_hold_full),
        .tx_empty (txe)
    );

    always_comb begin
        ovr_set = active && rx_sr_full && (fifo_en ? rx_fifo_full : rx_hold_full);
        unr_set = active && tx_en && tx_sr_empty && txe && slot_hit;

        st_d          = st_q;
        st_d.tx_empty = 1'b0;
        st_d.rx_ovr   = ovr_set || (st_q.rx_ovr && !stat_rd);
        st_d.tx_unr   = unr_set || (st_q.tx_unr && !stat_rd);
        st_d.tx_repeat = unr_set;

        if (!active || soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags          = st_q;
        flags.tx_empty = txe;
    end
endmodule

// File: rtl/sport_irq.sv
module sport_irq
    import sport_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_rst,
    input  logic [NCH-1:0] rx_ovr,
    input  logic [NCH-1:0] tx_unr,
    input  logic           ie_rx_glob,
    input  logic           ie_tx_glob,
    input  logic [NCH-1:0] ie_roe,
    input  logic [NCH-1:0] ie_tue,
    output logic           irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = (ie_rx_glob && |(rx_ovr & ie_roe)) ||
                (ie_tx_glob && |(tx_unr & ie_tue));
        if (soft_rst) irq_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/sport_err_status.sv
module sport_err_status
    import sport_pkg::*;
#(
    parameter  int LVL_W  = 4,
    parameter  int NSLOT  = 4,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               two_ch,
    input  logic               net_mode,
    input  logic [NCH-1:0]     fifo_en,
    input  logic [NCH*LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0]   tx_wmark,
    input  logic [NCH-1:0]     tx_hold_full,
    input  logic [NCH-1:0]     rx_fifo_full,
    input  logic [NCH-1:0]     rx_hold_full,
    input  logic [NCH-1:0]     rx_sr_full,
    input  logic [NCH-1:0]     tx_sr_empty,
    input  logic [NCH-1:0]     tx_en,
    input  logic               slot_strobe,
    input  logic [SLOT_W-1:0]  slot_idx,
    input  logic [NSLOT-1:0]   slot_mask,
    input  logic               stat_rd,
    input  logic               ie_rx_glob,
    input  logic               ie_tx_glob,
    input  logic [NCH-1:0]     ie_roe,
    input  logic [NCH-1:0]     ie_tue,
    output logic [NCH-1:0]     tx_empty,
    output logic [NCH-1:0]     rx_ovr,
    output logic [NCH-1:0]     tx_unr,
    output logic [NCH-1:0]     tx_repeat,
    output logic               irq
);
    logic        slot_masked;
    logic        slot_hit;
    chan_flags_t ch_flags [NCH];

    always_comb begin
        slot_masked = net_mode && slot_mask[slot_idx];
        slot_hit    = slot_strobe && !slot_masked;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ch_active;
        assign ch_active = (c == 0) ? 1'b1 : two_ch;

        sport_chan #(.LVL_W(LVL_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .soft_rst    (soft_rst),
            .active      (ch_active),
            .fifo_en     (fifo_en[c]),
            .tx_level    (tx_level[c*LVL_W +: LVL_W]),
            .tx_wmark    (tx_wmark),
            .tx_hold_full(tx_hold_full[c]),
            .rx_fifo_full(rx_fifo_full[c]),
            .rx_hold_full(rx_hold_full[c]),
            .rx_sr_full  (rx_sr_full[c]),
            .tx_sr_empty (tx_sr_empty[c]),
            .tx_en       (tx_en[c]),
            .slot_hit    (slot_hit),
            .stat_rd     (stat_rd),
            .flags       (ch_flags[c])
        );

        assign tx_empty[c]  = ch_flags[c].tx_empty;
        assign rx_ovr[c]    = ch_flags[c].rx_ovr;
        assign tx_unr[c]    = ch_flags[c].tx_unr;
        assign tx_repeat[c] = ch_flags[c].tx_repeat;
    end

    sport_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .rx_ovr    (rx_ovr),
        .tx_unr    (tx_unr),
        .ie_rx_glob(ie_rx_glob),
        .ie_tx_glob(ie_tx_glob),
        .ie_roe    (ie_roe),
        .ie_tue    (ie_tue),
        .irq       (irq)
    );
endmodule

// File: rtl/sport_err_chk.sv
module sport_err_chk #(
    parameter int NSLOT  = 4,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              two_ch,
    input logic              net_mode,
    input logic [1:0]        fifo_en,
    input logic [1:0]        rx_fifo_full,
    input logic [1:0]        rx_hold_full,
    input logic [1:0]        rx_sr_full,
    input logic              slot_strobe,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [NSLOT-1:0]  slot_mask,
    input logic              stat_rd,
    input logic              ie_rx_glob,
    input logic              ie_tx_glob,
    input logic [1:0]        ie_roe,
    input logic [1:0]        ie_tue,
    input logic [1:0]        tx_empty,
    input logic [1:0]        rx_ovr,
    input logic [1:0]        tx_unr,
    input logic [1:0]        tx_repeat,
    input logic              irq
);
    logic ovr0_cond;
    logic irq_src;
    assign ovr0_cond = rx_sr_full[0] && (fifo_en[0] ? rx_fifo_full[0] : rx_hold_full[0]);
    assign irq_src   = (ie_rx_glob && |(rx_ovr & ie_roe)) || (ie_tx_glob && |(tx_unr & ie_tue));

    // R5
    ovr0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr0_cond && !soft_rst) |=> rx_ovr[0]);

    // R8
    ovr0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr[0] && !stat_rd && !soft_rst) |=> rx_ovr[0]);

    // R8
    unr0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_unr[0] && !stat_rd && !soft_rst) |=> tx_unr[0]);

    // R6
    repeat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_repeat[0] |-> tx_unr[0]));

    // R6
    repeat_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_repeat[0] |=> !tx_repeat[0] || $past(slot_strobe));

    // R7
    masked_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_mode && slot_strobe && slot_mask[slot_idx]) |=> (tx_repeat == 2'b00));

    // R4
    ch1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !two_ch |=> (!tx_empty[1] && !rx_ovr[1] && !tx_unr[1] && !tx_repeat[1]));

    // R10
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (irq == $past(irq_src)));

    // R11
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_empty == 2'b00 && rx_ovr == 2'b00 && tx_unr == 2'b00 &&
                      tx_repeat == 2'b00 && !irq));
endmodule

bind sport_err_status sport_err_chk #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_err_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .two_ch      (two_ch),
    .net_mode    (net_mode),
    .fifo_en     (fifo_en),
    .rx_fifo_full(rx_fifo_full),
    .rx_hold_full(rx_hold_full),
    .rx_sr_full  (rx_sr_full),
    .slot_strobe (slot_strobe),
    .slot_idx    (slot_idx),
    .slot_mask   (slot_mask),
    .stat_rd     (stat_rd),
    .ie_rx_glob  (ie_rx_glob),
    .ie_tx_glob  (ie_tx_glob),
    .ie_roe      (ie_roe),
    .ie_tue      (ie_tue),
    .tx_empty    (tx_empty),
    .rx_ovr      (rx_ovr),
    .tx_unr      (tx_unr),
    .tx_repeat   (tx_repeat),
    .irq         (irq)
);

// File: tb/tb_sport_err_status.sv
module tb_sport_err_status;
    localparam int LVL_W = 4;
    localparam int NSLOT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst, two_ch, net_mode, slot_strobe, stat_rd, ie_rx_glob, ie_tx_glob;
    logic [1:0] fifo_en, tx_hold_full, rx_fifo_full, rx_hold_full, rx_sr_full;
    logic [1:0] tx_sr_empty, tx_en, ie_roe, ie_tue;
    logic [2*LVL_W-1:0] tx_level;
    logic [LVL_W-1:0] tx_wmark;
    logic [1:0] slot_idx;
    logic [NSLOT-1:0] slot_mask;
    logic [1:0] tx_empty, rx_ovr, tx_unr, tx_repeat;
    logic irq;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sport_err_status #(.LVL_W(LVL_W), .NSLOT(NSLOT)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .two_ch(two_ch),
        .net_mode(net_mode), .fifo_en(fifo_en), .tx_level(tx_level),
        .tx_wmark(tx_wmark), .tx_hold_full(tx_hold_full),
        .rx_fifo_full(rx_fifo_full), .rx_hold_full(rx_hold_full),
        .rx_sr_full(rx_sr_full), .tx_sr_empty(tx_sr_empty), .tx_en(tx_en),
        .slot_strobe(slot_strobe), .slot_idx(slot_idx), .slot_mask(slot_mask),
        .stat_rd(stat_rd), .ie_rx_glob(ie_rx_glob), .ie_tx_glob(ie_tx_glob),
        .ie_roe(ie_roe), .ie_tue(ie_tue), .tx_empty(tx_empty), .rx_ovr(rx_ovr),
        .tx_unr(tx_unr), .tx_repeat(tx_repeat), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        soft_rst = 0; two_ch = 1; net_mode = 0; slot_strobe = 0; stat_rd = 0;
        ie_rx_glob = 0; ie_tx_glob = 0; fifo_en = 0; tx_hold_full = 0;
        rx_fifo_full = 0; rx_hold_full = 0; rx_sr_full = 0; tx_sr_empty = 0;
        tx_en = 0; ie_roe = 0; ie_tue = 0; tx_level = 0; tx_wmark = 0;
        slot_idx = 0; slot_mask = 0;
    endtask

    task automatic clean();
        idle_inputs();
        soft_rst = 1; step();
        soft_rst = 0; step();
    endtask

    task automatic t_reset();
        idle_inputs();
        rx_sr_full = 2'b11; rx_hold_full = 2'b11;
        step(); step();
        chk("R1 outputs in reset", {tx_empty, rx_ovr, tx_unr, tx_repeat}, 8'h00);
        chk("R1 irq in reset", {7'd0, irq}, 8'h00);
        rst_n = 1;
        idle_inputs();
        step();
    endtask

    task automatic t_txe();
        clean();
        fifo_en = 2'b11; tx_wmark = 4'd3;
        tx_level = {4'd4, 4'd3}; step();
        chk("R2 level at wmark / above", {6'd0, tx_empty}, 8'h01);
        tx_level = {4'd0, 4'd4}; step();
        chk("R2 level above / zero", {6'd0, tx_empty}, 8'h02);
        fifo_en = 2'b00; tx_hold_full = 2'b01; step();
        chk("R3 hold full / empty", {6'd0, tx_empty}, 8'h02);
        tx_hold_full = 2'b00; step();
        chk("R3 hold empty", {6'd0, tx_empty}, 8'h03);
    endtask

    task automatic t_ch1_off();
        clean();
        two_ch = 0; rx_sr_full = 2'b10; rx_hold_full = 2'b10;
        tx_en = 2'b10; tx_sr_empty = 2'b10; slot_strobe = 1; step();
        chk("R4 ch1 silent", {tx_empty[1], rx_ovr[1], tx_unr[1], tx_repeat[1]}, 8'h00);
        slot_strobe = 0; two_ch = 1; step();
        chk("R4 ch1 live after enable", {6'd0, tx_empty[1], rx_ovr[1]}, 8'h03);
    endtask

    task automatic t_ovr();
        clean();
        fifo_en = 2'b01; rx_sr_full = 2'b01; rx_hold_full = 2'b01; step();
        chk("R5 unselected hold full ignored", {6'd0, rx_ovr}, 8'h00);
        rx_hold_full = 0; rx_fifo_full = 2'b01; step();
        chk("R5 fifo full overrun", {6'd0, rx_ovr}, 8'h01);
        clean();
        rx_sr_full = 2'b10; rx_hold_full = 2'b10; rx_fifo_full = 2'b01; step();
        chk("R5 register mode overrun", {6'd0, rx_ovr}, 8'h02);
    endtask

    task automatic t_unr();
        clean();
        tx_en = 2'b01; tx_sr_empty = 2'b01; step();
        chk("R6 no slot no underrun", {6'd0, tx_unr}, 8'h00);
        slot_strobe = 1; step();
        slot_strobe = 0;
        chk("R6 underrun set", {4'd0, tx_unr, tx_repeat}, 8'h05);
        step();
        chk("R6 repeat one cycle", {4'd0, tx_unr, tx_repeat}, 8'h04);
        clean();
        tx_en = 2'b01; tx_sr_empty = 2'b01; tx_hold_full = 2'b01; step();
        slot_strobe = 1; step();
        slot_strobe = 0;
        chk("R6 not empty no underrun", {6'd0, tx_unr}, 8'h00);
    endtask

    task automatic t_mask();
        clean();
        tx_en = 2'b01; tx_sr_empty = 2'b01;
        net_mode = 1; slot_mask = 4'b0100; slot_idx = 2; slot_strobe = 1; step();
        slot_strobe = 0;
        chk("R7 masked slot", {4'd0, tx_unr, tx_repeat}, 8'h00);
        slot_idx = 1; slot_strobe = 1; step();
        slot_strobe = 0;
        chk("R7 unmasked slot", {6'd0, tx_unr}, 8'h01);
        clean();
        tx_en = 2'b01; tx_sr_empty = 2'b01;
        slot_mask = 4'b0100; slot_idx = 2; slot_strobe = 1; step();
        slot_strobe = 0;
        chk("R7 mask ignored in normal mode", {6'd0, tx_unr}, 8'h01);
    endtask

    task automatic t_clear();
        clean();
        rx_sr_full = 2'b01; rx_hold_full = 2'b01; step();
        rx_sr_full = 0; step(); step();
        chk("R8 sticky", {6'd0, rx_ovr}, 8'h01);
        stat_rd = 1; step();
        stat_rd = 0;
        chk("R8 cleared by read", {6'd0, rx_ovr}, 8'h00);
        rx_sr_full = 2'b01; step();
        chk("R9 flag set again", {6'd0, rx_ovr}, 8'h01);
        stat_rd = 1; step();
        chk("R9 set wins over read", {6'd0, rx_ovr}, 8'h01);
        rx_sr_full = 0; step();
        stat_rd = 0;
        chk("R8 read clears after collision", {6'd0, rx_ovr}, 8'h00);
    endtask

    task automatic t_irq();
        clean();
        ie_rx_glob = 1; ie_roe = 2'b01;
        rx_sr_full = 2'b01; rx_hold_full = 2'b01; step();
        rx_sr_full = 0;
        chk("R10 irq lags flag", {6'd0, rx_ovr[0], irq}, 8'h02);
        step();
        chk("R10 irq raised", {7'd0, irq}, 8'h01);
        ie_rx_glob = 0; step();
        chk("R10 global enable off", {7'd0, irq}, 8'h00);
        ie_tx_glob = 1; ie_tue = 2'b10;
        tx_en = 2'b11; tx_sr_empty = 2'b11; slot_strobe = 1; step();
        slot_strobe = 0; tx_en = 0; step();
        chk("R10 underrun ch1 irq", {7'd0, irq}, 8'h01);
        soft_rst = 1; step();
        soft_rst = 0;
        chk("R11 soft reset clears", {tx_empty, rx_ovr, tx_unr, tx_repeat}, 8'h00);
        chk("R11 soft reset irq", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_txe();
        t_ch1_off();
        t_ovr();
        t_unr();
        t_mask();
        t_clear();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule